// File: doc/BRIEF.md
# Lock-step wide-bundle issue controller

This controller issues one wide instruction bundle at a time to a set of functional units. A bundle carries a fixed number of operation slots. Each slot feeds one unit type: slot 0 the integer ALU, slot 1 the multiplier and slot 2 the load/store unit. When a bundle is accepted, every slot that holds a real operation is launched to its unit in the same cycle. The controller does not look for hazards between the operations of one bundle, because the scheduler that built the bundle already guarantees they are independent.

After launch, the controller holds back the next bundle until every launched unit has reported completion with a done strobe. Latency may be fixed or variable. The memory unit is variable, so its completion is known only from its strobe. One slow operation therefore stalls the whole bundle, and this shows on a stall output. An empty slot carries the NOP opcode, launches nothing and counts as already complete.

Three wrapping counters record retired bundles, issued operations and stall cycles. Dividing operations by cycles gives the achieved issue rate.

Top module: `vliw_lockstep_issue`

## Requirements
- R1: During and right after reset, `bundle_ready` is 1, `stall` is 0, `slot_launch` is all zero and all three counters read 0.
- R2: Slot i sits at `bundle_opc[i*OPC_W +: OPC_W]` and `bundle_opnd[i*OPND_W +: OPND_W]`, and opcode 0 means NOP. In the cycle after an accepting edge (`bundle_valid` and `bundle_ready` both 1), `slot_launch[i]` is 1 for exactly the non-NOP slots, all together and for one cycle only. In that cycle `slot_opc` and `slot_opnd` show each slot's fields.
- R3: The controller makes no comparison between slots. Any mix of opcodes, including identical ones in every slot, launches in full.
- R4: `stall` is 1 from the launch cycle until the edge that samples the last outstanding done strobe, and `bundle_ready` is its inverse. A done strobe counts in the launch cycle or any later cycle, in any order. If the last strobe arrives M cycles after launch, `stall` is high for M+1 cycles.
- R5: While stalled, no further bundle is accepted or launched, whatever `bundle_valid` does. A bundle held on the input is accepted on the first edge with `bundle_ready` at 1.
- R6: A bundle made only of NOPs launches nothing and raises no stall. `bundle_ready` stays 1 in the next cycle, and the bundle retires on its accepting edge.
- R7: A `unit_done` strobe for a slot with no outstanding operation is ignored. It changes neither `stall`, `bundle_ready`, `slot_launch` nor any counter.
- R8: `cnt_retired` rises by one for each retired bundle. The new value shows in the cycle after the retiring edge.
- R9: `cnt_ops` rises by the bundle's number of non-NOP slots. The new value shows in the cycle after the accepting edge.
- R10: `cnt_stall` rises by one for every cycle with `stall` high. All counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid | input | 1 | A bundle is offered |
| bundle_ready | output | 1 | The controller can take a bundle |
| bundle_opc | input | SLOTS*OPC_W | Slot opcodes, 0 = NOP |
| bundle_opnd | input | SLOTS*OPND_W | Slot operands |
| slot_launch | output | SLOTS | One-cycle launch strobe per slot |
| slot_opc | output | SLOTS*OPC_W | Opcode held for each unit |
| slot_opnd | output | SLOTS*OPND_W | Operand held for each unit |
| unit_done | input | SLOTS | Completion strobe per unit |
| stall | output | 1 | A bundle is waiting for completions |
| cnt_retired | output | CNT_W | Retired bundle count |
| cnt_ops | output | CNT_W | Issued operation count |
| cnt_stall | output | CNT_W | Stall cycle count |

## Verification
The results fall due at three points. Launch strobes and the operation count appear one cycle after the accepting edge. An all-NOP bundle shows its retire count at that same point. Release of the stall, the return of `bundle_ready`, the retire count and the stall-cycle count appear one cycle after the edge that samples the last done strobe. The bench drives and samples only on falling edges and counts the launch cycle as cycle 0. A strobe for a delay of d is held during cycle d, so it checks the stall for M+1 cycles and the release right after them.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;

    // Unit role bound to each slot position, in slot order.
    typedef enum int unsigned {
        ROLE_ALU = 0,
        ROLE_MUL = 1,
        ROLE_LSU = 2
    } slot_role_e;

    localparam int unsigned ROLE_COUNT = 3;

    // Per-cycle events handed to the statistics block.
    typedef struct packed {
        logic retire;
        logic stall_cyc;
    } issue_evt_t;

endpackage

// File: rtl/vliw_slot_track.sv
module vliw_slot_track #(
    parameter int unsigned OPC_W  = 4,
    parameter int unsigned OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [OPND_W-1:0] opnd_i,
    input  logic              done_i,
    output logic              launch_o,
    output logic [OPC_W-1:0]  opc_o,
    output logic [OPND_W-1:0] opnd_o,
    output logic              pending_o,
    output logic              finish_o
);

    typedef struct packed {
        logic              pending;
        logic              launch;
        logic [OPC_W-1:0]  opc;
        logic [OPND_W-1:0] opnd;
    } trk_t;

    trk_t trk_d, trk_q;
    logic live;

    assign live = |opc_i;

    always_comb begin
        trk_d        = trk_q;
        trk_d.launch = 1'b0;
        if (accept_i) begin
            trk_d.opc     = opc_i;
            trk_d.opnd    = opnd_i;
            trk_d.launch  = live;
            trk_d.pending = live;
        end else if (trk_q.pending && done_i) begin
            trk_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign launch_o  = trk_q.launch;
    assign opc_o     = trk_q.opc;
    assign opnd_o    = trk_q.opnd;
    assign pending_o = trk_q.pending;
    assign finish_o  = trk_q.pending & done_i;

endmodule

// File: rtl/vliw_issue_counters.sv
module vliw_issue_counters
    import vliw_issue_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OPS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  issue_evt_t       evt_i,
    input  logic [OPS_W-1:0] add_ops_i,
    output logic [CNT_W-1:0] retired_o,
    output logic [CNT_W-1:0] ops_o,
    output logic [CNT_W-1:0] stalls_o
);

    typedef struct packed {
        logic [CNT_W-1:0] retired;
        logic [CNT_W-1:0] ops;
        logic [CNT_W-1:0] stalls;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.ops = cnt_q.ops + CNT_W'(add_ops_i);
        if (evt_i.retire) begin
            cnt_d.retired = cnt_q.retired + 1'b1;
        end
        if (evt_i.stall_cyc) begin
            cnt_d.stalls = cnt_q.stalls + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign retired_o = cnt_q.retired;
    assign ops_o     = cnt_q.ops;
    assign stalls_o  = cnt_q.stalls;

endmodule

// File: rtl/vliw_lockstep_issue.sv
module vliw_lockstep_issue
    import vliw_issue_pkg::*;
#(
    parameter int unsigned SLOTS  = ROLE_COUNT,
    parameter int unsigned OPC_W  = 4,
    parameter int unsigned OPND_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bundle_valid,
    output logic                    bundle_ready,
    input  logic [SLOTS*OPC_W-1:0]  bundle_opc,
    input  logic [SLOTS*OPND_W-1:0] bundle_opnd,
    output logic [SLOTS-1:0]        slot_launch,
    output logic [SLOTS*OPC_W-1:0]  slot_opc,
    output logic [SLOTS*OPND_W-1:0] slot_opnd,
    input  logic [SLOTS-1:0]        unit_done,
    output logic                    stall,
    output logic [CNT_W-1:0]        cnt_retired,
    output logic [CNT_W-1:0]        cnt_ops,
    output logic [CNT_W-1:0]        cnt_stall
);

    localparam int unsigned OPS_W = $clog2(SLOTS + 1);

    logic             accept;
    logic [SLOTS-1:0] live;
    logic [SLOTS-1:0] pending;
    logic [SLOTS-1:0] finish;
    logic [SLOTS-1:0] left_over;
    logic [OPS_W-1:0] issue_n;
    logic [OPS_W-1:0] add_ops;
    issue_evt_t       evt;

    // One tracker per slot; no slot looks at any other slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign live[s] = |bundle_opc[s*OPC_W +: OPC_W];

        vliw_slot_track #(
            .OPC_W  (OPC_W),
            .OPND_W (OPND_W)
        ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .accept_i  (accept),
            .opc_i     (bundle_opc[s*OPC_W +: OPC_W]),
            .opnd_i    (bundle_opnd[s*OPND_W +: OPND_W]),
            .done_i    (unit_done[s]),
            .launch_o  (slot_launch[s]),
            .opc_o     (slot_opc[s*OPC_W +: OPC_W]),
            .opnd_o    (slot_opnd[s*OPND_W +: OPND_W]),
            .pending_o (pending[s]),
            .finish_o  (finish[s])
        );
    end

    always_comb begin
        issue_n = '0;
        for (int s = 0; s < SLOTS; s++) begin
            issue_n = issue_n + OPS_W'(live[s]);
        end
    end

    assign bundle_ready = ~|pending;
    assign stall        = |pending;
    assign accept       = bundle_valid & bundle_ready;
    assign left_over    = pending & ~finish;
    assign add_ops      = accept ? issue_n : '0;

    // Retire: an empty bundle on acceptance, otherwise when the last
    // outstanding slot is cleared.
    always_comb begin
        evt.retire    = (accept && (issue_n == '0)) ||
                        ((|pending) && !(|left_over));
        evt.stall_cyc = |pending;
    end

    vliw_issue_counters #(
        .CNT_W (CNT_W),
        .OPS_W (OPS_W)
    ) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .add_ops_i (add_ops),
        .retired_o (cnt_retired),
        .ops_o     (cnt_ops),
        .stalls_o  (cnt_stall)
    );

endmodule

// File: rtl/vliw_issue_checker.sv
module vliw_issue_checker #(
    parameter int unsigned SLOTS  = 3,
    parameter int unsigned OPC_W  = 4,
    parameter int unsigned OPND_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bundle_valid,
    input logic                    bundle_ready,
    input logic [SLOTS*OPC_W-1:0]  bundle_opc,
    input logic [SLOTS-1:0]        slot_launch,
    input logic [SLOTS*OPC_W-1:0]  slot_opc,
    input logic [SLOTS*OPND_W-1:0] slot_opnd,
    input logic [SLOTS-1:0]        unit_done,
    input logic                    stall,
    input logic [CNT_W-1:0]        cnt_retired,
    input logic [CNT_W-1:0]        cnt_ops,
    input logic [CNT_W-1:0]        cnt_stall
);

    logic [SLOTS-1:0] in_live;
    logic [SLOTS-1:0] held_live;
    logic [CNT_W-1:0] in_count;
    logic             acc;

    always_comb begin
        in_count = '0;
        for (int s = 0; s < SLOTS; s++) begin
            in_live[s]   = |bundle_opc[s*OPC_W +: OPC_W];
            held_live[s] = |slot_opc[s*OPC_W +: OPC_W];
            in_count     = in_count + CNT_W'(in_live[s]);
        end
    end

    assign acc = bundle_valid && bundle_ready;

    a_r2_launch_mask: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (slot_launch == $past(in_live)));

    a_r2_launch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_launch) |=> (slot_launch == '0));

    a_r3_launch_matches_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_launch) |-> (slot_launch == held_live));

    a_r4_stall_in_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_launch) |-> stall);

    a_r5_no_launch_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (slot_launch == '0));

    a_r5_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(slot_opnd));

    a_r6_empty_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (in_live == '0)) |=> (!stall && bundle_ready));

    a_r7_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !bundle_valid && (|unit_done)) |=>
        (!stall && (slot_launch == '0) && $stable(cnt_retired) && $stable(cnt_ops)));

    a_r8_retire_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (cnt_retired == $past(cnt_retired) + 1'b1));

    a_r9_ops_count: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (cnt_ops == $past(cnt_ops) + $past(in_count)));

    a_r10_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (cnt_stall == $past(cnt_stall) + 1'b1));

    a_r10_stall_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> $stable(cnt_stall));

endmodule

bind vliw_lockstep_issue vliw_issue_checker #(
    .SLOTS  (SLOTS),
    .OPC_W  (OPC_W),
    .OPND_W (OPND_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bundle_valid (bundle_valid),
    .bundle_ready (bundle_ready),
    .bundle_opc   (bundle_opc),
    .slot_launch  (slot_launch),
    .slot_opc     (slot_opc),
    .slot_opnd    (slot_opnd),
    .unit_done    (unit_done),
    .stall        (stall),
    .cnt_retired  (cnt_retired),
    .cnt_ops      (cnt_ops),
    .cnt_stall    (cnt_stall)
);

// File: tb/vliw_lockstep_issue_test.sv
`timescale 1ns/1ps
module vliw_lockstep_issue_test;

    localparam int unsigned SLOTS  = 3;
    localparam int unsigned OPC_W  = 4;
    localparam int unsigned OPND_W = 32;
    localparam int unsigned CNT_W  = 16;
    localparam int          NV     = 8;

    // Entry: {opc slot2, slot1, slot0 (12 bits), delay0, delay1, delay2 (8 bits each)}
    // delay = cycles after the launch cycle at which that unit's done is driven
    localparam logic [35:0] VEC [NV] = '{
        36'h321_00_00_00,   // all three, done in launch cycle
        36'h000_05_05_05,   // all NOP
        36'h500_00_00_07,   // memory only, slow
        36'h031_02_04_00,   // ALU + MUL, MUL slowest
        36'h9A1_01_03_14,   // all three, memory slowest (20)
        36'h407_05_00_00,   // ALU + memory, ALU slowest
        36'h060_00_01_00,   // MUL only
        36'hFFF_0A_0A_0A    // identical opcodes everywhere
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bundle_valid = 1'b0;
    logic                    bundle_ready;
    logic [SLOTS*OPC_W-1:0]  bundle_opc = '0;
    logic [SLOTS*OPND_W-1:0] bundle_opnd = '0;
    logic [SLOTS-1:0]        slot_launch;
    logic [SLOTS*OPC_W-1:0]  slot_opc;
    logic [SLOTS*OPND_W-1:0] slot_opnd;
    logic [SLOTS-1:0]        unit_done = '0;
    logic                    stall;
    logic [CNT_W-1:0]        cnt_retired;
    logic [CNT_W-1:0]        cnt_ops;
    logic [CNT_W-1:0]        cnt_stall;

    int total = 0;
    int bad   = 0;
    int exp_ret = 0;
    int exp_ops = 0;
    int exp_stl = 0;

    always #4 clk = ~clk;

    vliw_lockstep_issue #(
        .SLOTS (SLOTS), .OPC_W (OPC_W), .OPND_W (OPND_W), .CNT_W (CNT_W)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .bundle_valid (bundle_valid), .bundle_ready (bundle_ready),
        .bundle_opc (bundle_opc), .bundle_opnd (bundle_opnd),
        .slot_launch (slot_launch), .slot_opc (slot_opc), .slot_opnd (slot_opnd),
        .unit_done (unit_done), .stall (stall),
        .cnt_retired (cnt_retired), .cnt_ops (cnt_ops), .cnt_stall (cnt_stall)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [OPND_W-1:0] opnd_of(input int tag, input int s);
        return OPND_W'(32'hA000 + tag * 16 + s);
    endfunction

    task automatic drive_bundle(input logic [11:0] opc, input int tag);
        bundle_opc = opc;
        for (int s = 0; s < SLOTS; s++) bundle_opnd[s*OPND_W +: OPND_W] = opnd_of(tag, s);
    endtask

    task automatic check_counters(input string req);
        chk(int'(cnt_retired) == exp_ret, req, "cnt_retired", cnt_retired, exp_ret);
        chk(int'(cnt_ops) == exp_ops, "R9", "cnt_ops", cnt_ops, exp_ops);
        chk(int'(cnt_stall) == exp_stl, "R10", "cnt_stall", cnt_stall, exp_stl);
    endtask

    // Caller is at a falling edge with the controller idle.
    task automatic run_bundle(input logic [35:0] e, input int tag);
        logic [11:0]      opc;
        logic [SLOTS-1:0] mask;
        int dly [SLOTS];
        int n, m;
        opc = e[35:24];
        dly[0] = int'(e[23:16]); dly[1] = int'(e[15:8]); dly[2] = int'(e[7:0]);
        n = 0; m = 0;
        for (int s = 0; s < SLOTS; s++) begin
            mask[s] = |opc[s*4 +: 4];
            if (mask[s]) begin
                n++;
                if (dly[s] > m) m = dly[s];
            end
        end
        chk(bundle_ready == 1'b1, "R5", "ready before bundle", bundle_ready, 1);
        bundle_valid = 1'b1;
        drive_bundle(opc, tag);
        @(negedge clk);
        bundle_valid = 1'b0;
        exp_ops += n;
        chk(slot_launch == mask, "R2", "launch mask", slot_launch, mask);
        chk(slot_opc == opc, "R3", "slot_opc", slot_opc, opc);
        for (int s = 0; s < SLOTS; s++)
            if (mask[s])
                chk(slot_opnd[s*OPND_W +: OPND_W] == opnd_of(tag, s), "R2", "slot operand",
                    slot_opnd[s*OPND_W +: OPND_W], opnd_of(tag, s));
        if (n == 0) begin
            exp_ret++;
            chk(!stall && bundle_ready, "R6", "stall after empty bundle", stall, 0);
            check_counters("R6");
            return;
        end
        for (int c = 0; c <= m; c++) begin
            chk(stall && !bundle_ready, "R4", "stall while waiting", stall, 1);
            if (c > 0) chk(slot_launch == '0, "R2", "launch pulse width", slot_launch, 0);
            for (int s = 0; s < SLOTS; s++) unit_done[s] = mask[s] && (dly[s] == c);
            @(negedge clk);
        end
        unit_done = '0;
        exp_stl += m + 1;
        exp_ret++;
        chk(!stall && bundle_ready, "R4", "release after last done", stall, 0);
        check_counters("R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(bundle_ready && !stall, "R1", "ready/stall in reset", stall, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bundle_ready == 1'b1, "R1", "ready after reset", bundle_ready, 1);
        chk(slot_launch == '0, "R1", "launch after reset", slot_launch, 0);
        check_counters("R1");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            run_bundle(VEC[v], v);
            @(negedge clk);
        end

        // R7: stray done strobes while idle
        unit_done = '1;
        @(negedge clk);
        unit_done = '0;
        chk(!stall && bundle_ready, "R7", "stall after stray done", stall, 0);
        chk(slot_launch == '0, "R7", "launch after stray done", slot_launch, 0);
        check_counters("R7");

        // R5: second bundle held on the input while the first waits for memory
        bundle_valid = 1'b1;
        drive_bundle(12'h500, 20);
        @(negedge clk);
        drive_bundle(12'h011, 21);
        exp_ops += 1;
        chk(slot_launch == 3'b100, "R5", "first bundle launch", slot_launch, 3'b100);
        for (int c = 0; c <= 3; c++) begin
            chk(!bundle_ready && stall, "R5", "held while stalled", bundle_ready, 0);
            if (c > 0) chk(slot_launch == '0, "R5", "no launch while held", slot_launch, 0);
            unit_done = (c == 3) ? 3'b100 : 3'b001;   // early slot0 done is stray
            @(negedge clk);
        end
        unit_done = '0;
        exp_stl += 4;
        exp_ret++;
        chk(bundle_ready && slot_launch == '0, "R5", "held bundle not launched yet",
            slot_launch, 0);
        check_counters("R8");
        @(negedge clk);
        bundle_valid = 1'b0;
        exp_ops += 2;
        chk(slot_launch == 3'b011, "R5", "held bundle launched", slot_launch, 3'b011);
        chk(slot_opnd[OPND_W +: OPND_W] == opnd_of(21, 1), "R2", "held operand",
            slot_opnd[OPND_W +: OPND_W], opnd_of(21, 1));
        chk(stall == 1'b1, "R4", "stall in launch cycle", stall, 1);
        unit_done = 3'b011;
        @(negedge clk);
        unit_done = '0;
        exp_stl += 1;
        exp_ret++;
        chk(!stall && bundle_ready, "R4", "release", stall, 0);
        check_counters("R8");

        finish_run();
    end

endmodule